// File: doc/BRIEF.md
# Shared Asynchronous Memory Bus Bridge

This block connects an on-chip memory-mapped slave port to one external bus. That bus carries address, data, per-device active-low chip selects, read and write strobes and byte enables. Several asynchronous memories sit on the bus, for example a byte-wide flash and a word-wide SRAM. They share the address and data lines, and only one of them is in use at a time. The master supplies a byte address. The top bits of that address pick the device, and the remaining bits go out on the external address lines unchanged. A device with wider words simply leaves its lowest address lines unconnected.

Each device has its own setup, strobe and hold times, given in nanoseconds. At elaboration these are rounded up to whole clock cycles, with a minimum of one. While the bridge walks the external cycle through those three phases, it holds waitrequest high toward the master. Every signal the bridge drives onto the bus comes straight from a register. The data bus is split into output, output enable and input so that the pad tristate buffer can sit outside the block. An optional register on the returning data adds one cycle to reads. It does not change any phase length that a device sees.

Top module: `extbus_bridge`

## Requirements
- R1: While reset is asserted, and immediately when it is asserted in the middle of an access, every `ext_cs_n` bit is 1, `ext_rd_n` and `ext_wr_n` are 1 and `ext_doe` is 0. With no request pending, `mst_wait` is 0.
- R2: Master address bits [25:24] select the device. Value 0 drives `ext_cs_n[0]` low and value 1 drives `ext_cs_n[1]` low. No more than one chip select is ever low.
- R3: While a chip select is low, `ext_addr` equals master address bits [23:0] and stays constant.
- R4: An access to a mapped device holds its chip select low with both strobes high for S cycles. It then holds the matching strobe (`ext_rd_n` for a read, `ext_wr_n` for a write) low for W cycles. It then holds the chip select low with both strobes high for H cycles. The other strobe never goes low.
- R5: S, W and H are each ceil(time_ns / CLK_NS), with a minimum of 1. With the defaults, device 0 uses 5/20/5 cycles and device 1 uses 2/3/1 cycles (its zero hold time is raised to one cycle).
- R6: `ext_doe` is 1 in exactly the cycles in which a write holds its chip select low. It is 0 during every read and every idle cycle. During the write strobe, `ext_dout` equals the master write data.
- R7: From the edge that accepts a request, `mst_wait` stays high for S+W+H cycles on a write. On a read it stays high for S+W+H+1 cycles when IN_REG is 1. It then goes low for one cycle, in which the access completes.
- R8: Read data is the value present on `ext_din` in the last strobe cycle. It appears on `mst_rdata` in the cycle in which `mst_wait` is low.
- R9: Address select values 2 and 3 are unmapped. No chip select goes low, the access completes on the first cycle after acceptance, read data is 0, and a write changes no device contents.
- R10: While a chip select is low, `ext_be_n` is the inverse of `mst_be`.
- R11: All chip selects are high in the completion cycle. A request presented in that completion cycle is taken one cycle later, after an idle cycle in which its `mst_wait` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_addr | input | 26 | Master byte address; bits [25:24] select the device |
| mst_read | input | 1 | Read request, held until `mst_wait` is low |
| mst_write | input | 1 | Write request, held until `mst_wait` is low |
| mst_wdata | input | 32 | Write data |
| mst_be | input | 4 | Byte enables, active high |
| mst_rdata | output | 32 | Read data, valid when `mst_wait` is low |
| mst_wait | output | 1 | Stall toward the master |
| ext_addr | output | 24 | External byte address |
| ext_dout | output | 32 | Data driven onto the bus |
| ext_doe | output | 1 | Output enable for the data pad buffers |
| ext_din | input | 32 | Data returned from the bus |
| ext_cs_n | output | 2 | Active-low chip select, one per device |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_be_n | output | 4 | Active-low byte enables |

## Verification
The bench drives a request at a falling edge. From the next falling edge on, it samples 1 ns after each falling edge, so every sample lands in a full cycle after the registers have updated. It expects `mst_wait` to stay high for S+W+H samples on a write and S+W+H+1 on a read, and one more sample when the request arrives in the previous completion cycle. It sorts the samples with a low chip select into setup, strobe and hold phases by the strobe level, and compares each count with the value computed from the nanosecond times. Read data is compared in the first sample with `mst_wait` low. An access to an unmapped device must complete in the very first sample.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    // Phase of the external access sequencer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_INREG,
        PH_ACK
    } phase_e;

    // Round a time in nanoseconds up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) begin
            c = 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/extbus_decode.sv
module extbus_decode #(
    parameter int SEL_W   = 2,
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic             hit,
    output logic [DEV_W-1:0] idx
);

    // A select value names a device when it is below the device count.
    always_comb begin
        hit = (int'(sel) < NUM_DEV);
        idx = DEV_W'(sel);
    end

endmodule

// File: rtl/extbus_timing.sv
module extbus_timing #(
    parameter int                    NUM_DEV  = 2,
    parameter int                    DEV_W    = 1,
    parameter int                    CNT_W    = 8,
    parameter int                    CLK_NS   = 8,
    parameter logic [NUM_DEV*16-1:0] SETUP_NS = '0,
    parameter logic [NUM_DEV*16-1:0] WAIT_NS  = '0,
    parameter logic [NUM_DEV*16-1:0] HOLD_NS  = '0
) (
    input  logic [DEV_W-1:0] idx,
    output logic [CNT_W-1:0] setup_m1,
    output logic [CNT_W-1:0] wait_m1,
    output logic [CNT_W-1:0] hold_m1
);

    logic [CNT_W-1:0] setup_tbl [NUM_DEV];
    logic [CNT_W-1:0] wait_tbl  [NUM_DEV];
    logic [CNT_W-1:0] hold_tbl  [NUM_DEV];

    // One entry per device, each phase stored as cycle count minus one.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        localparam int SC = extbus_pkg::ns_to_cycles(int'(SETUP_NS[g*16 +: 16]), CLK_NS);
        localparam int WC = extbus_pkg::ns_to_cycles(int'(WAIT_NS[g*16 +: 16]), CLK_NS);
        localparam int HC = extbus_pkg::ns_to_cycles(int'(HOLD_NS[g*16 +: 16]), CLK_NS);
        assign setup_tbl[g] = CNT_W'(SC - 1);
        assign wait_tbl[g]  = CNT_W'(WC - 1);
        assign hold_tbl[g]  = CNT_W'(HC - 1);
    end

    always_comb begin
        setup_m1 = '0;
        wait_m1  = '0;
        hold_m1  = '0;
        if (int'(idx) < NUM_DEV) begin
            setup_m1 = setup_tbl[idx];
            wait_m1  = wait_tbl[idx];
            hold_m1  = hold_tbl[idx];
        end
    end

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq #(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int BE_W    = 4,
    parameter int CNT_W   = 8,
    parameter bit IN_REG  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]    req_be,
    input  logic               dec_hit,
    input  logic [DEV_W-1:0]   dec_idx,
    input  logic [CNT_W-1:0]   setup_m1,
    input  logic [CNT_W-1:0]   wait_m1,
    input  logic [CNT_W-1:0]   hold_m1,
    output logic [DEV_W-1:0]   tim_idx,
    output logic               mst_wait,
    output logic [DATA_W-1:0]  mst_rdata,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic [NUM_DEV-1:0] ext_cs_n,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [BE_W-1:0]    ext_be_n
);
    import extbus_pkg::*;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [DEV_W-1:0]   dev;
        logic               is_wr;
        logic               cap;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  dout;
        logic [BE_W-1:0]    be_n;
        logic [NUM_DEV-1:0] cs_n;
        logic               rd_n;
        logic               wr_n;
        logic               oe;
        logic [DATA_W-1:0]  rdata;
    } seq_state_t;

    seq_state_t q, d;
    logic [DATA_W-1:0] din_q;
    logic req_any;
    logic strobe_end_rd;

    // Optional register on the returning data bus.
    if (IN_REG) begin : g_inreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                din_q <= '0;
            end else begin
                din_q <= ext_din;
            end
        end
    end else begin : g_direct
        assign din_q = ext_din;
    end

    assign req_any = req_rd | req_wr;
    assign tim_idx = (q.ph == PH_IDLE) ? dec_idx : q.dev;

    always_comb begin
        d = q;
        strobe_end_rd = (q.ph == PH_STROBE) && (q.cnt == '0) && !q.is_wr;
        d.cap = strobe_end_rd;
        unique case (q.ph)
            PH_IDLE: begin
                if (req_any) begin
                    d.addr  = req_addr;
                    d.dout  = req_wdata;
                    d.be_n  = ~req_be;
                    d.is_wr = req_wr;
                    d.dev   = dec_idx;
                    if (dec_hit) begin
                        d.ph   = PH_SETUP;
                        d.cnt  = setup_m1;
                        d.cs_n = ~(NUM_DEV'(1) << dec_idx);
                        d.oe   = req_wr;
                    end else begin
                        d.ph = PH_ACK;
                        if (!req_wr) begin
                            d.rdata = '0;
                        end
                    end
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_STROBE;
                    d.cnt = wait_m1;
                    if (q.is_wr) begin
                        d.wr_n = 1'b0;
                    end else begin
                        d.rd_n = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (q.cnt == '0) begin
                    d.ph   = PH_HOLD;
                    d.cnt  = hold_m1;
                    d.rd_n = 1'b1;
                    d.wr_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.cs_n = '1;
                    d.oe   = 1'b0;
                    d.ph   = (IN_REG && !q.is_wr) ? PH_INREG : PH_ACK;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_INREG: d.ph = PH_ACK;
            PH_ACK:   d.ph = PH_IDLE;
            default:  d.ph = PH_IDLE;
        endcase
        // Capture read data: straight from the pins at the last strobe edge,
        // or one edge later from the input register.
        if (IN_REG ? q.cap : strobe_end_rd) begin
            d.rdata = din_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= '1;
            q.rd_n <= 1'b1;
            q.wr_n <= 1'b1;
            q.be_n <= '1;
        end else begin
            q <= d;
        end
    end

    assign mst_wait  = req_any && (q.ph != PH_ACK);
    assign mst_rdata = q.rdata;
    assign ext_addr  = q.addr;
    assign ext_dout  = q.dout;
    assign ext_doe   = q.oe;
    assign ext_cs_n  = q.cs_n;
    assign ext_rd_n  = q.rd_n;
    assign ext_wr_n  = q.wr_n;
    assign ext_be_n  = q.be_n;

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~q.cs_n));

    // R6
    oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.rd_n);

    // R4
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.rd_n || !q.wr_n) |-> !(&q.cs_n));

    // R4
    hold_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rd_n) |-> !(&q.cs_n));

    // R4
    hold_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wr_n) |-> !(&q.cs_n));

    // R7
    ack_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_ACK) |-> (&q.cs_n && q.rd_n && q.wr_n && !q.oe));

    // R9
    unmapped_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && req_any && !dec_hit) |=> (q.ph == PH_ACK && &q.cs_n));

endmodule

// File: rtl/extbus_bridge.sv
module extbus_bridge #(
    parameter int                    NUM_DEV  = 2,
    parameter int                    SEL_W    = 2,
    parameter int                    ADDR_W   = 24,
    parameter int                    DATA_W   = 32,
    parameter int                    CNT_W    = 8,
    parameter int                    CLK_NS   = 8,
    parameter bit                    IN_REG   = 1'b1,
    parameter logic [NUM_DEV*16-1:0] SETUP_NS = {16'd10, 16'd40},
    parameter logic [NUM_DEV*16-1:0] WAIT_NS  = {16'd20, 16'd160},
    parameter logic [NUM_DEV*16-1:0] HOLD_NS  = {16'd0,  16'd40},
    localparam int                   MST_AW   = ADDR_W + SEL_W,
    localparam int                   BE_W     = DATA_W / 8,
    localparam int                   DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MST_AW-1:0]  mst_addr,
    input  logic               mst_read,
    input  logic               mst_write,
    input  logic [DATA_W-1:0]  mst_wdata,
    input  logic [BE_W-1:0]    mst_be,
    output logic [DATA_W-1:0]  mst_rdata,
    output logic               mst_wait,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic [NUM_DEV-1:0] ext_cs_n,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [BE_W-1:0]    ext_be_n
);

    logic             dec_hit;
    logic [DEV_W-1:0] dec_idx;
    logic [DEV_W-1:0] tim_idx;
    logic [CNT_W-1:0] setup_m1;
    logic [CNT_W-1:0] wait_m1;
    logic [CNT_W-1:0] hold_m1;

    extbus_decode #(
        .SEL_W   (SEL_W),
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) decode_i (
        .sel (mst_addr[MST_AW-1 -: SEL_W]),
        .hit (dec_hit),
        .idx (dec_idx)
    );

    extbus_timing #(
        .NUM_DEV  (NUM_DEV),
        .DEV_W    (DEV_W),
        .CNT_W    (CNT_W),
        .CLK_NS   (CLK_NS),
        .SETUP_NS (SETUP_NS),
        .WAIT_NS  (WAIT_NS),
        .HOLD_NS  (HOLD_NS)
    ) timing_i (
        .idx      (tim_idx),
        .setup_m1 (setup_m1),
        .wait_m1  (wait_m1),
        .hold_m1  (hold_m1)
    );

    extbus_seq #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BE_W    (BE_W),
        .CNT_W   (CNT_W),
        .IN_REG  (IN_REG)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (mst_read),
        .req_wr    (mst_write),
        .req_addr  (mst_addr[ADDR_W-1:0]),
        .req_wdata (mst_wdata),
        .req_be    (mst_be),
        .dec_hit   (dec_hit),
        .dec_idx   (dec_idx),
        .setup_m1  (setup_m1),
        .wait_m1   (wait_m1),
        .hold_m1   (hold_m1),
        .tim_idx   (tim_idx),
        .mst_wait  (mst_wait),
        .mst_rdata (mst_rdata),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_doe   (ext_doe),
        .ext_din   (ext_din),
        .ext_cs_n  (ext_cs_n),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_be_n  (ext_be_n)
    );

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ext_cs_n) && $past(!(&ext_cs_n))) |-> $stable(ext_addr));

    // R10
    be_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&ext_cs_n) && $past(!(&ext_cs_n))) |-> $stable(ext_be_n));

endmodule

// File: tb/extbus_bridge_tb_top.sv
module extbus_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [25:0] mst_addr;
    logic        mst_read;
    logic        mst_write;
    logic [31:0] mst_wdata;
    logic [3:0]  mst_be;
    logic [31:0] mst_rdata;
    logic        mst_wait;
    logic [23:0] ext_addr;
    logic [31:0] ext_dout;
    logic        ext_doe;
    logic [31:0] ext_din;
    logic [1:0]  ext_cs_n;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [3:0]  ext_be_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    extbus_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_addr  (mst_addr),
        .mst_read  (mst_read),
        .mst_write (mst_write),
        .mst_wdata (mst_wdata),
        .mst_be    (mst_be),
        .mst_rdata (mst_rdata),
        .mst_wait  (mst_wait),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .ext_doe   (ext_doe),
        .ext_din   (ext_din),
        .ext_cs_n  (ext_cs_n),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_be_n  (ext_be_n)
    );

    // Behavioural devices: byte-wide flash on lanes [7:0] (device 0),
    // word-wide SRAM (device 1) that ignores byte address bits [1:0].
    logic [7:0]  flash_mem [16];
    logic [31:0] sram_mem  [16];

    initial begin
        for (int i = 0; i < 16; i++) begin
            flash_mem[i] = 8'h00;
            sram_mem[i]  = 32'h0;
        end
    end

    always_comb begin
        if (!ext_cs_n[1] && !ext_rd_n) begin
            ext_din = sram_mem[ext_addr[5:2]];
        end else if (!ext_cs_n[0] && !ext_rd_n) begin
            ext_din = {24'h0, flash_mem[ext_addr[3:0]]};
        end else begin
            ext_din = 32'h0;
        end
    end

    always @(posedge clk) begin
        if (!ext_cs_n[1] && !ext_wr_n && ext_doe) begin
            for (int b = 0; b < 4; b++) begin
                if (!ext_be_n[b]) begin
                    sram_mem[ext_addr[5:2]][b*8 +: 8] <= ext_dout[b*8 +: 8];
                end
            end
        end
        if (!ext_cs_n[0] && !ext_wr_n && ext_doe && !ext_be_n[0]) begin
            flash_mem[ext_addr[3:0]] <= ext_dout[7:0];
        end
    end

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns + 7) / 8;
        if (c < 1) c = 1;
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one access and observes it sample by sample until mst_wait drops.
    task automatic run_access(input bit wr, input logic [25:0] a, input logic [31:0] wd,
                              input logic [3:0] be, input int extra,
                              input logic [31:0] exp_rd);
        int busy;
        int n_set;
        int n_stb;
        int n_hold;
        int dev;
        int es;
        int ew;
        int eh;
        int exp_busy;
        bit mapped;
        bit seen_stb;
        bit bad_cs;
        bit bad_addr;
        bit bad_be;
        bit bad_oe;
        bit bad_dout;
        bit bad_kind;
        bit stb_low;
        busy = 0; n_set = 0; n_stb = 0; n_hold = 0;
        seen_stb = 0; bad_cs = 0; bad_addr = 0; bad_be = 0;
        bad_oe = 0; bad_dout = 0; bad_kind = 0;
        dev    = int'(a[25:24]);
        mapped = (dev < 2);
        es = (dev == 0) ? to_cyc(40)  : to_cyc(10);
        ew = (dev == 0) ? to_cyc(160) : to_cyc(20);
        eh = (dev == 0) ? to_cyc(40)  : to_cyc(0);
        mst_addr  = a;
        mst_read  = !wr;
        mst_write = wr;
        mst_wdata = wd;
        mst_be    = be;
        @(negedge clk);
        while (1) begin
            #1;
            if (!mst_wait) break;
            busy++;
            if (mapped) begin
                if (ext_cs_n[1 - dev] == 1'b0) bad_cs = 1;
                if (ext_cs_n[dev] == 1'b0) begin
                    if (ext_addr != a[23:0]) bad_addr = 1;
                    if (ext_be_n != ~be) bad_be = 1;
                    if (ext_doe != wr) bad_oe = 1;
                    if (wr ? !ext_rd_n : !ext_wr_n) bad_kind = 1;
                    stb_low = wr ? !ext_wr_n : !ext_rd_n;
                    if (stb_low) begin
                        seen_stb = 1;
                        n_stb++;
                        if (wr && ext_dout != wd) bad_dout = 1;
                    end else if (seen_stb) begin
                        n_hold++;
                    end else begin
                        n_set++;
                    end
                end else begin
                    if (ext_doe) bad_oe = 1;
                    if (!ext_rd_n || !ext_wr_n) bad_kind = 1;
                end
            end else begin
                if (ext_cs_n != 2'b11) bad_cs = 1;
            end
            @(negedge clk);
        end
        // Completion cycle
        exp_busy = mapped ? (es + ew + eh + (wr ? 0 : 1) + extra) : extra;
        check(busy == exp_busy, "R7 wait cycles", 32'(busy), 32'(exp_busy));
        check(ext_cs_n == 2'b11, "R11 chip selects high at completion",
              32'(ext_cs_n), 32'h3);
        check(ext_doe == 1'b0, "R6 output enable low at completion",
              32'(ext_doe), 32'h0);
        if (mapped) begin
            check(n_set == es, "R4/R5 setup cycles", 32'(n_set), 32'(es));
            check(n_stb == ew, "R4/R5 strobe cycles", 32'(n_stb), 32'(ew));
            check(n_hold == eh, "R4/R5 hold cycles", 32'(n_hold), 32'(eh));
            check(!bad_cs, "R2 only selected chip select low", 32'(bad_cs), 32'h0);
            check(!bad_addr, "R3 address passthrough", 32'(bad_addr), 32'h0);
            check(!bad_be, "R10 byte enables", 32'(bad_be), 32'h0);
            check(!bad_oe, "R6 output enable window", 32'(bad_oe), 32'h0);
            check(!bad_kind, "R4 wrong strobe", 32'(bad_kind), 32'h0);
            if (wr) check(!bad_dout, "R6 write data on bus", 32'(bad_dout), 32'h0);
        end else begin
            check(!bad_cs, "R9 no chip select when unmapped", 32'(bad_cs), 32'h0);
        end
        if (!wr) begin
            check(mst_rdata == exp_rd, mapped ? "R8 read data" : "R9 unmapped read data",
                  mst_rdata, exp_rd);
        end
    endtask

    task automatic go_idle();
        mst_read  = 1'b0;
        mst_write = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [25:0] a;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 26'h100_0010, 32'hA5A5_1234, 4'hF, 32'h0000_0000},
        '{1'b0, 26'h100_0010, 32'h0000_0000, 4'hF, 32'hA5A5_1234},
        '{1'b1, 26'h100_0012, 32'h0000_7700, 4'h2, 32'h0000_0000},
        '{1'b0, 26'h100_0010, 32'h0000_0000, 4'hF, 32'hA5A5_7734},
        '{1'b1, 26'h000_0003, 32'h0000_005C, 4'h1, 32'h0000_0000},
        '{1'b0, 26'h000_0003, 32'h0000_0000, 4'h1, 32'h0000_005C},
        '{1'b0, 26'h000_0004, 32'h0000_0000, 4'h1, 32'h0000_0000},
        '{1'b0, 26'h200_0000, 32'h0000_0000, 4'hF, 32'h0000_0000},
        '{1'b1, 26'h300_0010, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000},
        '{1'b0, 26'h100_0010, 32'h0000_0000, 4'hF, 32'hA5A5_7734}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog expired actual=hung expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        mst_addr  = '0;
        mst_read  = 1'b0;
        mst_write = 1'b0;
        mst_wdata = '0;
        mst_be    = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(ext_cs_n == 2'b11, "R1 chip selects in reset", 32'(ext_cs_n), 32'h3);
        check(ext_rd_n && ext_wr_n, "R1 strobes in reset",
              32'({ext_rd_n, ext_wr_n}), 32'h3);
        check(ext_doe == 1'b0, "R1 output enable in reset", 32'(ext_doe), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(mst_wait == 1'b0, "R1 no stall without request", 32'(mst_wait), 32'h0);
        check(ext_cs_n == 2'b11, "R1 idle after reset", 32'(ext_cs_n), 32'h3);

        // Table of accesses, each started from idle
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            run_access(VECS[i].wr, VECS[i].a, VECS[i].wd, VECS[i].be, 0, VECS[i].exp);
            go_idle();
        end

        // R11 back-to-back: next request presented in the completion cycle
        @(negedge clk);
        run_access(1'b1, 26'h100_0020, 32'h1357_9BDF, 4'hF, 0, 32'h0);
        run_access(1'b0, 26'h000_0003, 32'h0, 4'h1, 1, 32'h0000_005C);
        run_access(1'b0, 26'h100_0020, 32'h0, 4'hF, 1, 32'h1357_9BDF);
        go_idle();

        // R9 unmapped read back-to-back after a mapped write
        @(negedge clk);
        run_access(1'b1, 26'h000_0005, 32'h0000_00A1, 4'h1, 0, 32'h0);
        run_access(1'b0, 26'h300_0005, 32'h0, 4'hF, 1, 32'h0);
        go_idle();
        @(negedge clk);
        run_access(1'b0, 26'h000_0005, 32'h0, 4'h1, 0, 32'h0000_00A1);
        go_idle();

        // R1 reset in the middle of a write
        @(negedge clk);
        mst_addr  = 26'h100_0030;
        mst_wdata = 32'h2468_ACE0;
        mst_be    = 4'hF;
        mst_write = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(ext_wr_n == 1'b0, "R4 write strobe active before reset",
              32'(ext_wr_n), 32'h0);
        rst_n = 1'b0;
        #1;
        check(ext_cs_n == 2'b11, "R1 chip selects on mid-access reset",
              32'(ext_cs_n), 32'h3);
        check(ext_wr_n && ext_rd_n, "R1 strobes on mid-access reset",
              32'({ext_rd_n, ext_wr_n}), 32'h3);
        check(ext_doe == 1'b0, "R1 output enable on mid-access reset",
              32'(ext_doe), 32'h0);
        go_idle();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_access(1'b0, 26'h100_0010, 32'h0, 4'hF, 0, 32'hA5A5_7734);
        go_idle();
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule